// File: doc/BRIEF.md
# Standby Mode Controller

This block decides when a small 8-bit CPU may enter one of three low-power standby modes, and when it must leave them. Software writes a three-bit request word. One bit asks for stop, one for watch and one for sleep. The controller accepts the request only when the main clock is reported stable and no peripheral interrupt is pending at a live priority. An accepted request moves the block into the chosen mode on the next clock edge. In that mode the block halts the CPU and gates the clock domains that the mode switches off.

While the device sits in any standby mode, a pending interrupt at a live priority brings it back to run mode. This happens whether or not the CPU would accept that interrupt. On the cycle of return the block raises a one-cycle wake pulse together with a decision. The decision says either to branch to the interrupt routine or to resume at the instruction after the standby request. The decision compares the best pending level against the CPU's current level mask and its global enable.

A refused request is dropped, not held. The device therefore never drops into standby later, after the blocking interrupt has been serviced. All pins are plain control and status pins. No stream data flows through this block, so there is no valid/ready handshake and no back-pressure.

Top module: `stby_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the block holds these values: mode is RUN (2'b00), cpu_halt is 0, clk_gate is 3'b000, and wake_pulse and wake_take are 0.
- R2: A write (wr_en high at a clock edge) made in run mode with exactly one request bit set changes the mode at that edge. The request bits are wr_bits[2] = stop, wr_bits[1] = watch and wr_bits[0] = sleep. The mode codes are RUN = 2'b00, SLEEP = 2'b01, STOP = 2'b10 and WATCH = 2'b11. A write of 3'b000 leaves the block in RUN.
- R3: When several request bits are set in one write, the chosen mode is STOP if bit 2 is set. Otherwise it is WATCH if bit 1 is set.
- R4: A write is refused and the block stays in RUN if any irq_pend[i] is set whose level irq_lvl[2i+1:2i] is not 2'b11. The refused request is discarded, so clearing the interrupt afterwards does not start standby. A request pending at level 2'b11 does not block entry.
- R5: A write is refused and the block stays in RUN while clk_stable is 0.
- R6: In every standby mode cpu_halt is 1. clk_gate bit 0 gates the CPU clock, bit 1 gates the peripheral clock and bit 2 gates the timebase/watch clock. The gate values are 3'b001 in SLEEP, 3'b111 in STOP and 3'b011 in WATCH. In RUN the value is 3'b000.
- R7: In any standby mode, a pending request at a level other than 2'b11 returns the mode to RUN at the next edge, whatever cpu_ie and cpu_lvl are. wake_pulse is high for exactly that one following cycle. A request pending only at level 2'b11 does not wake the block.
- R8: While wake_pulse is high, wake_take is 1 only if cpu_ie was 1 and the numerically smallest live pending level was less than cpu_lvl, both taken at the waking edge. Level 2'b00 is the highest priority. Otherwise wake_take is 0, which means resume at the next instruction. wake_take is 0 whenever wake_pulse is 0.
- R9: Writes made while in a standby mode are ignored, and the mode stays unchanged.
- R10: After a wake-up, once the interrupt requests are cleared, a new write enters standby again under the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Request-register write strobe |
| wr_bits | input | 3 | Request bits: [2] stop, [1] watch, [0] sleep |
| irq_pend | input | NIRQ | Peripheral interrupt pending flags |
| irq_lvl | input | 2*NIRQ | Two-bit level per request, request i at [2i+1:2i] |
| clk_stable | input | 1 | Main clock reported stable |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_lvl | input | 2 | CPU current interrupt level field |
| mode | output | 2 | Current mode (RUN/SLEEP/STOP/WATCH) |
| cpu_halt | output | 1 | Halts the CPU while in standby |
| clk_gate | output | 3 | Gate enables: [0] CPU, [1] peripheral, [2] timebase |
| wake_pulse | output | 1 | One-cycle pulse on return to RUN |
| wake_take | output | 1 | With wake_pulse: 1 = take interrupt, 0 = resume |

## Verification
The bench blocks entry with an interrupt and then clears it. A design that queued the refused request would fall asleep once the interrupt was serviced. It also checks that level 2'b11 neither blocks entry nor wakes the block; a design that got this wrong would halt forever or never sleep. It writes all-ones and two-bit request words to catch a wrong priority order. It wakes with the CPU level equal to the request level and with interrupts disabled. A comparator that used less-or-equal, or one that tied the wake itself to the enable, would take the wrong branch or stay halted.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_DEAD = 2'b11;
  localparam int GATE_W = 3;

  typedef enum logic [1:0] {
    M_RUN   = 2'b00,
    M_SLEEP = 2'b01,
    M_STOP  = 2'b10,
    M_WATCH = 2'b11
  } mode_e;

  // gate bits: [0] cpu clock, [1] peripheral clock, [2] timebase clock
  function automatic logic [GATE_W-1:0] gate_of(mode_e m);
    case (m)
      M_SLEEP: gate_of = 3'b001;
      M_STOP:  gate_of = 3'b111;
      M_WATCH: gate_of = 3'b011;
      default: gate_of = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/stby_irq_scan.sv
module stby_irq_scan
  import stby_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NIRQ-1:0]       irq_pend,
  input  logic [LVL_W*NIRQ-1:0] irq_lvl,
  output logic                  any_live,
  output logic [LVL_W-1:0]      best_lvl
);
  logic [NIRQ-1:0] live;

  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_live
      assign live[g] = irq_pend[g] && (irq_lvl[LVL_W*g +: LVL_W] != LVL_DEAD);
    end
  endgenerate

  always_comb begin
    best_lvl = LVL_DEAD;
    for (int i = 0; i < NIRQ; i++) begin
      if (live[i] && (irq_lvl[LVL_W*i +: LVL_W] < best_lvl))
        best_lvl = irq_lvl[LVL_W*i +: LVL_W];
    end
  end

  assign any_live = |live;

  // R8: a live request always yields a best level above the dead one
  p_best_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_live |-> (best_lvl != LVL_DEAD));
endmodule

// File: rtl/stby_mode_pick.sv
module stby_mode_pick
  import stby_pkg::*;
(
  input  logic [2:0] bits,
  output logic       valid,
  output mode_e      pick
);
  always_comb begin
    valid = 1'b1;
    if (bits[2])      pick = M_STOP;
    else if (bits[1]) pick = M_WATCH;
    else if (bits[0]) pick = M_SLEEP;
    else begin
      pick  = M_RUN;
      valid = 1'b0;
    end
  end

  // R3: stop request always wins
  always_comb begin
    if (bits[2]) p_stop_first_r3: assert (pick == M_STOP);
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  pick_valid,
  input  mode_e pick,
  input  logic  clk_stable,
  input  logic  any_live,
  input  logic  take_ok,
  output mode_e mode_q,
  output logic  wake_q,
  output logic  take_q
);
  logic accept;
  assign accept = wr_en && pick_valid && clk_stable && !any_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      wake_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      take_q <= 1'b0;
      if (mode_q == M_RUN) begin
        if (accept) mode_q <= pick;
      end else if (any_live) begin
        mode_q <= M_RUN;
        wake_q <= 1'b1;
        take_q <= take_ok;
      end
    end
  end

  // R4: a blocking interrupt keeps the block running
  p_refuse_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && any_live) |=> (mode_q == M_RUN));
  // R5: unstable clock keeps the block running
  p_refuse_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !clk_stable) |=> (mode_q == M_RUN));
  // R7: a live request in standby returns to run with a pulse
  p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN && any_live) |=> (mode_q == M_RUN && wake_q));
  p_wake_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  // R8: the decision is only given with the pulse
  p_take_with_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> wake_q);
  // R9: standby holds without a live request, writes or not
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN && !any_live) |=> $stable(mode_q));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_bits,
  input  logic [NIRQ-1:0]       irq_pend,
  input  logic [LVL_W*NIRQ-1:0] irq_lvl,
  input  logic                  clk_stable,
  input  logic                  cpu_ie,
  input  logic [LVL_W-1:0]      cpu_lvl,
  output logic [1:0]            mode,
  output logic                  cpu_halt,
  output logic [GATE_W-1:0]     clk_gate,
  output logic                  wake_pulse,
  output logic                  wake_take
);
  logic             any_live;
  logic [LVL_W-1:0] best_lvl;
  logic             pick_valid;
  mode_e            pick;
  mode_e            mode_q;

  stby_irq_scan #(.NIRQ(NIRQ)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pend (irq_pend),
    .irq_lvl  (irq_lvl),
    .any_live (any_live),
    .best_lvl (best_lvl)
  );

  stby_mode_pick u_pick (
    .bits  (wr_bits),
    .valid (pick_valid),
    .pick  (pick)
  );

  stby_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .pick_valid (pick_valid),
    .pick       (pick),
    .clk_stable (clk_stable),
    .any_live   (any_live),
    .take_ok    (cpu_ie && (best_lvl < cpu_lvl)),
    .mode_q     (mode_q),
    .wake_q     (wake_pulse),
    .take_q     (wake_take)
  );

  assign mode     = mode_q;
  assign cpu_halt = (mode_q != M_RUN);
  assign clk_gate = gate_of(mode_q);

  // R6: the CPU clock is gated exactly while halted
  p_halt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt == clk_gate[0]);
endmodule

// File: tb/stby_ctrl_tb_top.sv
module stby_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NIRQ  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [2:0]      wr_bits;
  logic [NIRQ-1:0] irq_pend;
  logic [2*NIRQ-1:0] irq_lvl;
  logic            clk_stable;
  logic            cpu_ie;
  logic [1:0]      cpu_lvl;
  logic [1:0]      mode;
  logic            cpu_halt;
  logic [2:0]      clk_gate;
  logic            wake_pulse;
  logic            wake_take;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  stby_ctrl #(.NIRQ(NIRQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bits(wr_bits),
    .irq_pend(irq_pend), .irq_lvl(irq_lvl), .clk_stable(clk_stable),
    .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl), .mode(mode), .cpu_halt(cpu_halt),
    .clk_gate(clk_gate), .wake_pulse(wake_pulse), .wake_take(wake_take)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(logic [2:0] b);
    wr_en = 1'b1; wr_bits = b;
    step(1);
    wr_en = 1'b0; wr_bits = 3'b000;
  endtask

  // raise request 1 at level lv, check return to run and decision
  task automatic wake(logic [1:0] lv, logic ie, logic [1:0] cl, int exp_take, string req);
    cpu_ie = ie; cpu_lvl = cl;
    irq_lvl[3:2] = lv; irq_pend[1] = 1'b1;
    step(1);
    chk(req, "wake mode", mode, 0);
    chk("R7", "wake pulse", wake_pulse, 1);
    chk(req, "wake take", wake_take, exp_take);
    irq_pend = '0; irq_lvl = '0;
    step(1);
    chk("R7", "pulse one cycle", wake_pulse, 0);
    chk("R8", "take low off pulse", wake_take, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_bits = 3'b000; irq_pend = '0; irq_lvl = '0;
    clk_stable = 1'b1; cpu_ie = 1'b0; cpu_lvl = 2'b11;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1", "mode", mode, 0);
    chk("R1", "halt", cpu_halt, 0);
    chk("R1", "gate", clk_gate, 0);
    chk("R1", "wake", wake_pulse, 0);
    chk("R1", "take", wake_take, 0);
  endtask

  task automatic t_sleep();
    do_write(3'b000);
    chk("R2", "zero write stays run", mode, 0);
    do_write(3'b001);
    chk("R2", "sleep mode", mode, 1);
    chk("R6", "sleep halt", cpu_halt, 1);
    chk("R6", "sleep gate", clk_gate, 3'b001);
    wake(2'b01, 1'b1, 2'b10, 1, "R8");
  endtask

  task automatic t_stop();
    do_write(3'b100);
    chk("R2", "stop mode", mode, 2);
    chk("R6", "stop gate", clk_gate, 3'b111);
    wake(2'b00, 1'b0, 2'b11, 0, "R8");
  endtask

  task automatic t_watch();
    do_write(3'b010);
    chk("R2", "watch mode", mode, 3);
    chk("R6", "watch gate", clk_gate, 3'b011);
    irq_lvl[1:0] = 2'b11; irq_pend[0] = 1'b1;
    step(2);
    chk("R7", "dead level no wake", mode, 3);
    irq_pend = '0; irq_lvl = '0;
    wake(2'b10, 1'b1, 2'b10, 0, "R8");
  endtask

  task automatic t_priority();
    do_write(3'b111);
    chk("R3", "all bits -> stop", mode, 2);
    wake(2'b00, 1'b1, 2'b01, 1, "R8");
    do_write(3'b011);
    chk("R3", "watch over sleep", mode, 3);
    wake(2'b01, 1'b1, 2'b01, 0, "R8");
    do_write(3'b110);
    chk("R3", "stop over watch", mode, 2);
    wake(2'b00, 1'b1, 2'b11, 1, "R8");
  endtask

  task automatic t_refuse_irq();
    irq_lvl[5:4] = 2'b00; irq_pend[2] = 1'b1;
    do_write(3'b001);
    chk("R4", "refused while pending", mode, 0);
    irq_pend = '0; irq_lvl = '0;
    step(3);
    chk("R4", "refusal not retained", mode, 0);
    irq_lvl[7:6] = 2'b11; irq_pend[3] = 1'b1;
    do_write(3'b001);
    chk("R4", "dead level does not block", mode, 1);
    irq_pend = '0; irq_lvl = '0;
    wake(2'b10, 1'b1, 2'b11, 1, "R8");
  endtask

  task automatic t_refuse_clk();
    clk_stable = 1'b0;
    do_write(3'b100);
    chk("R5", "refused clock unstable", mode, 0);
    step(2);
    chk("R5", "still run", mode, 0);
    clk_stable = 1'b1;
  endtask

  task automatic t_ignore_write();
    do_write(3'b001);
    chk("R9", "enter sleep", mode, 1);
    do_write(3'b100);
    chk("R9", "write in standby ignored", mode, 1);
    do_write(3'b010);
    chk("R9", "second write ignored", mode, 1);
    wake(2'b01, 1'b0, 2'b11, 0, "R8");
  endtask

  task automatic t_reenter();
    do_write(3'b010);
    chk("R10", "re-enter watch", mode, 3);
    wake(2'b00, 1'b1, 2'b01, 1, "R10");
    do_write(3'b001);
    chk("R10", "re-enter sleep", mode, 1);
    wake(2'b11 ^ 2'b10, 1'b1, 2'b10, 1, "R10");
  endtask

  initial begin
    t_reset();
    t_sleep();
    t_stop();
    t_watch();
    t_priority();
    t_refuse_irq();
    t_refuse_clk();
    t_ignore_write();
    t_reenter();
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule